// File: doc/BRIEF.md
# Four-Phase Handshake Register Port

This block is a synchronous slave port through which an external host reads and writes a small internal register bank. Every input is sampled on the rising edge of one bus clock. The host pulls an active-low select to begin an access, and a direction input chooses between read and write. The port answers with an active-low acknowledge. The acknowledge stays low until the host lets go of select, which makes this a full four-phase request/acknowledge handshake. Data moves over a 16-bit bus that is split into an output half (with a per-bit output enable) and an input half. In the bus numbering, bit 0 is the most significant bit.

A state machine with four states sequences each access. **ST_IDLE** waits for select. **ST_LEAD** and **ST_SETTLE** are the two cycles that come before acknowledge. **ST_ACK** holds acknowledge until select is released. The transitions are:

- *start*: ST_IDLE to ST_LEAD, when select is sampled low.
- *advance*: ST_LEAD to ST_SETTLE, when select is still low.
- *grant*: ST_SETTLE to ST_ACK, when select is still low. A write commits its data on this edge.
- *hold*: ST_ACK to itself, while select stays low.
- *release*: ST_ACK to ST_IDLE, when select is high.
- *abort*: ST_LEAD or ST_SETTLE to ST_IDLE, when select is high. No write takes place.

The size inputs choose between a word access and a byte access. The bank holds 64 words, indexed by address bits 6..1, and address bit 0 picks the byte half.

Top module: `hsk_slave_port`

## Requirements
- R1: When a rising edge samples `sel_n`=0 and `rd_wr`=1 in ST_IDLE, `bus_oe` is nonzero and `bus_o` carries the read value from that same edge onward.
- R2: `ack_n` goes low after the third rising edge of an access (the start edge plus two more), provided select stays low throughout.
- R3: While `ack_n` is low and `sel_n` stays low, `ack_n` stays low and `bus_o`/`bus_oe` do not change.
- R4: In ST_ACK, the edge that samples `sel_n`=1 returns `ack_n` high and sets `bus_oe` to zero together.
- R5: The rising edge right after `ack_n` returns high may begin a new access, so back-to-back accesses complete without an idle cycle.
- R6: Size 2'b01 is a byte access. Only bus bits 8..15 are enabled (`bus_oe`=16'h00FF) and bits 0..7 read as zero. Address bit 0 = 0 selects the upper (most significant) half of the word, and address bit 0 = 1 selects the lower half.
- R7: Size 2'b00 is a word access, and sizes 2'b10 and 2'b11 are treated the same way. All 16 bits are enabled, with bus bit 0 as the most significant bit, and address bit 0 is ignored.
- R8: When a rising edge samples `sel_n`=0 and `rd_wr`=0, a write starts. `data_i` is captured on the edge where acknowledge is granted. A byte write takes bus bits 8..15 into the selected half only and leaves the other half unchanged.
- R9: If select goes high in ST_LEAD or ST_SETTLE, the port returns to idle. `ack_n` never falls and no register changes.
- R10: After reset, `ack_n` is 1, `bus_oe` is 0 and every register reads 0.
- R11: `alt_mode` stays low, because only the handshake mode exists.
- R12: During a write, `bus_oe` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock; all inputs sampled on its rising edge |
| rst_n | input | 1 | Active-low reset |
| sel_n | input | 1 | Active-low access select from the host |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr_i | input | 7 | Access address; bits 6..1 pick a word, bit 0 picks the byte half |
| size_i | input | 2 | 2'b01 byte, any other value word |
| data_i | input | 16 | Write data from the bus, bit 0 most significant |
| ack_n | output | 1 | Active-low acknowledge |
| bus_o | output | 16 | Read data onto the bus, bit 0 most significant |
| bus_oe | output | 16 | Per-bit output enable for `bus_o` |
| alt_mode | output | 1 | Alternate-bus-mode indicator, always low here |

## Verification
The hardest conditions to create from the ports are the two aborts. In each, select is withdrawn after the start edge but before acknowledge, and the abort in ST_SETTLE lands on the very edge that would otherwise commit a write. The bench releases select on the falling edge after one or two start-side edges. It then reads the target word back to show it is still zero, and it watches `ack_n` so that it never falls. Back-to-back accesses are covered by running every table vector with select dropping again on the falling edge right after the release.

// File: rtl/hsk_pkg.sv
package hsk_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LEAD   = 2'd1,
        ST_SETTLE = 2'd2,
        ST_ACK    = 2'd3
    } hsk_state_t;

    localparam logic [1:0] SZ_WORD = 2'b00;
    localparam logic [1:0] SZ_BYTE = 2'b01;

endpackage

// File: rtl/hsk_fsm.sv
module hsk_fsm
    import hsk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic sel_n,
    input  logic rd_wr,
    output logic start,
    output logic capture,
    output logic ack_n,
    output logic drive
);

    hsk_state_t state, nxt;
    logic       rd_q;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)     rd_q <= 1'b0;
        else if (start) rd_q <= rd_wr;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE:   nxt = sel_n ? ST_IDLE : ST_LEAD;   // start
            ST_LEAD:   nxt = sel_n ? ST_IDLE : ST_SETTLE; // abort / advance
            ST_SETTLE: nxt = sel_n ? ST_IDLE : ST_ACK;    // abort / grant
            ST_ACK:    nxt = sel_n ? ST_IDLE : ST_ACK;    // release / hold
            default:   nxt = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        start   = (state == ST_IDLE) && !sel_n;
        capture = (state == ST_SETTLE) && !sel_n && !rd_q;
        ack_n   = (state != ST_ACK);
        drive   = rd_q && (state != ST_IDLE);
    end

    // R2: acknowledge falls only after three consecutive select-low samples
    p_ack_delay_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ack_n) |-> (!$past(sel_n, 1) && !$past(sel_n, 2) && !$past(sel_n, 3)));

    // R3: acknowledge held while select stays low
    p_ack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !sel_n) |=> !ack_n);

    // R4: release drops acknowledge and the bus together
    p_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && sel_n) |=> (ack_n && !drive));

    // R9: early release returns to idle without acknowledge
    p_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_LEAD || state == ST_SETTLE) && sel_n) |=> (state == ST_IDLE && ack_n));

endmodule

// File: rtl/hsk_lane.sv
module hsk_lane #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] word_i,
    input  logic [DATA_W-1:0] bus_i,
    input  logic              byte_i,
    input  logic              half_i,
    output logic [DATA_W-1:0] rd_val,
    output logic [DATA_W-1:0] wr_val
);

    localparam int HALF = DATA_W / 2;

    always_comb begin
        if (!byte_i) begin
            rd_val = word_i;
            wr_val = bus_i;
        end else if (half_i) begin
            rd_val = {{HALF{1'b0}}, word_i[HALF-1:0]};
            wr_val = {word_i[DATA_W-1:HALF], bus_i[HALF-1:0]};
        end else begin
            rd_val = {{HALF{1'b0}}, word_i[DATA_W-1:HALF]};
            wr_val = {bus_i[HALF-1:0], word_i[HALF-1:0]};
        end
    end

endmodule

// File: rtl/hsk_regbank.sv
module hsk_regbank #(
    parameter int DATA_W = 16,
    parameter int IDX_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata
);

    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] mem [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n)
                mem[g] <= '0;
            else if (we && (idx == IDX_W'(g)))
                mem[g] <= wdata;
        end
    end

    assign rdata = mem[idx];

endmodule

// File: rtl/hsk_slave_port.sv
module hsk_slave_port
    import hsk_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_n,
    input  logic              rd_wr,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [1:0]        size_i,
    input  logic [0:DATA_W-1] data_i,
    output logic              ack_n,
    output logic [0:DATA_W-1] bus_o,
    output logic [0:DATA_W-1] bus_oe,
    output logic              alt_mode
);

    localparam int HALF  = DATA_W / 2;
    localparam int IDX_W = ADDR_W - 1;
    localparam logic [DATA_W-1:0] LO_MASK = {{HALF{1'b0}}, {HALF{1'b1}}};

    logic              start, capture, drive;
    logic [ADDR_W-1:0] addr_q;
    logic              byte_q;
    logic [DATA_W-1:0] rdata_q;
    logic [DATA_W-1:0] bank_word, rd_val, wr_val, bus_in;
    logic [IDX_W-1:0]  idx;
    logic              byte_sel, half_sel;

    hsk_fsm u_fsm (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel_n   (sel_n),
        .rd_wr   (rd_wr),
        .start   (start),
        .capture (capture),
        .ack_n   (ack_n),
        .drive   (drive)
    );

    assign idx      = start ? addr_i[ADDR_W-1:1] : addr_q[ADDR_W-1:1];
    assign byte_sel = start ? (size_i == SZ_BYTE) : byte_q;
    assign half_sel = start ? addr_i[0] : addr_q[0];
    assign bus_in   = data_i;

    hsk_regbank #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_bank (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (capture),
        .idx   (idx),
        .wdata (wr_val),
        .rdata (bank_word)
    );

    hsk_lane #(.DATA_W(DATA_W)) u_lane (
        .word_i (bank_word),
        .bus_i  (bus_in),
        .byte_i (byte_sel),
        .half_i (half_sel),
        .rd_val (rd_val),
        .wr_val (wr_val)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            byte_q  <= 1'b0;
            rdata_q <= '0;
        end else if (start) begin
            addr_q  <= addr_i;
            byte_q  <= (size_i == SZ_BYTE);
            rdata_q <= rd_wr ? rd_val : '0;
        end
    end

    assign bus_o    = drive ? rdata_q : '0;
    assign bus_oe   = drive ? (byte_q ? LO_MASK : '1) : '0;
    assign alt_mode = 1'b0;

    // R1: a sampled read start enables the bus from that edge
    p_read_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (start && rd_wr) |=> (bus_oe != '0));

    // R3: read data stable during the hold phase
    p_data_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_n && !sel_n) |=> ($stable(bus_o) && $stable(bus_oe)));

    // R6: only full or low-half lane patterns appear
    p_lanes_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_oe != '0) |-> (bus_oe == '1 || bus_oe == LO_MASK));

    // R12: a write start never enables the bus
    p_write_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !rd_wr) |=> (bus_oe == '0));

endmodule

// File: tb/hsk_slave_port_test.sv
module hsk_slave_port_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sel_n = 1'b1;
    logic        rd_wr = 1'b1;
    logic [6:0]  addr_i = '0;
    logic [1:0]  size_i = '0;
    logic [0:15] data_i = '0;
    logic        ack_n;
    logic [0:15] bus_o;
    logic [0:15] bus_oe;
    logic        alt_mode;

    int total = 0;
    int bad   = 0;

    always #10 clk = ~clk;

    hsk_slave_port uut (
        .clk(clk), .rst_n(rst_n), .sel_n(sel_n), .rd_wr(rd_wr),
        .addr_i(addr_i), .size_i(size_i), .data_i(data_i),
        .ack_n(ack_n), .bus_o(bus_o), .bus_oe(bus_oe), .alt_mode(alt_mode)
    );

    task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one full handshake access; returns values seen at key points
    task automatic access(input bit rd, input logic [1:0] sz, input logic [6:0] a,
                          input logic [15:0] wd, output logic [15:0] got,
                          output logic [15:0] got_oe, output int edges,
                          output bit held, output bit released, output bit quiet);
        quiet = 1'b1;
        sel_n = 1'b0; rd_wr = rd; size_i = sz; addr_i = a; data_i = wd;
        @(posedge clk); @(negedge clk);
        edges  = 1;
        got    = bus_o;
        got_oe = bus_oe;
        if (!rd && bus_oe != '0) quiet = 1'b0;
        while (ack_n && edges < 20) begin
            @(posedge clk); @(negedge clk);
            edges++;
            if (!rd && bus_oe != '0) quiet = 1'b0;
        end
        @(posedge clk); @(negedge clk);
        held = !ack_n && (bus_o == got) && (bus_oe == got_oe);
        if (!rd && bus_oe != '0) quiet = 1'b0;
        sel_n = 1'b1;
        @(posedge clk); @(negedge clk);
        released = ack_n && (bus_oe == '0);
    endtask

    // rd, size, addr, wdata, expected read, expected oe
    localparam int NV = 12;
    localparam logic [57:0] VEC [NV] = '{
        {1'b0, 2'b00, 7'h10, 16'hA5C3, 16'h0000, 16'h0000},
        {1'b1, 2'b00, 7'h10, 16'h0000, 16'hA5C3, 16'hFFFF},
        {1'b0, 2'b01, 7'h11, 16'hEE3C, 16'h0000, 16'h0000},
        {1'b1, 2'b00, 7'h10, 16'h0000, 16'hA53C, 16'hFFFF},
        {1'b1, 2'b01, 7'h10, 16'h0000, 16'h00A5, 16'h00FF},
        {1'b1, 2'b01, 7'h11, 16'h0000, 16'h003C, 16'h00FF},
        {1'b0, 2'b01, 7'h20, 16'hFF77, 16'h0000, 16'h0000},
        {1'b1, 2'b00, 7'h21, 16'h0000, 16'h7700, 16'hFFFF},
        {1'b0, 2'b11, 7'h7E, 16'h1234, 16'h0000, 16'h0000},
        {1'b1, 2'b00, 7'h7F, 16'h0000, 16'h1234, 16'hFFFF},
        {1'b1, 2'b10, 7'h7E, 16'h0000, 16'h1234, 16'hFFFF},
        {1'b1, 2'b00, 7'h00, 16'h0000, 16'h0000, 16'hFFFF}
    };

    initial begin
        repeat (100000) @(posedge clk);
        bad++; total++;
        $display("FAIL R5 watchdog: handshake did not complete actual=0 expected=1");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [15:0] got, got_oe;
        int edges;
        bit held, rel, quiet;
        bit ack_seen;

        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R10 reset state, R11 mode pin
        chk(ack_n == 1'b1, "R10 ack after reset", 16'(ack_n), 16'h1);
        chk(bus_oe == '0, "R10 oe after reset", bus_oe, 16'h0);
        chk(alt_mode == 1'b0, "R11 mode pin", 16'(alt_mode), 16'h0);

        // table walk: back-to-back accesses (R5)
        for (int i = 0; i < NV; i++) begin
            access(VEC[i][57], VEC[i][56:55], VEC[i][54:48], VEC[i][47:32],
                   got, got_oe, edges, held, rel, quiet);
            chk(edges == 3, "R2 ack delay", 16'(edges), 16'd3);
            chk(held, "R3 hold", 16'(held), 16'h1);
            chk(rel, "R4 release", 16'(rel), 16'h1);
            if (VEC[i][57]) begin
                chk(got == VEC[i][31:16], "R1/R6/R7 read value R8", got, VEC[i][31:16]);
                chk(got_oe == VEC[i][15:0], "R6/R7 lane enable", got_oe, VEC[i][15:0]);
            end else begin
                chk(quiet, "R12 write leaves bus undriven", 16'(quiet), 16'h1);
            end
        end

        // R7: bus bit 0 is the most significant bit
        access(1'b1, 2'b00, 7'h10, 16'h0, got, got_oe, edges, held, rel, quiet);
        chk(got == 16'hA53C, "R7 word read", got, 16'hA53C);
        sel_n = 1'b0; rd_wr = 1'b1; size_i = 2'b00; addr_i = 7'h10;
        @(posedge clk); @(negedge clk);
        chk(bus_o[0] == 1'b1 && bus_o[15] == 1'b0, "R7 bit0 msb", {bus_o[0], bus_o[15]}, 16'h2);
        sel_n = 1'b1;
        @(posedge clk); @(negedge clk);

        // R9: abort in lead cycle
        ack_seen = 1'b0;
        sel_n = 1'b0; rd_wr = 1'b0; size_i = 2'b00; addr_i = 7'h30; data_i = 16'hBEEF;
        @(posedge clk); @(negedge clk);
        sel_n = 1'b1;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            if (!ack_n) ack_seen = 1'b1;
        end
        chk(!ack_seen, "R9 abort lead no ack", 16'(ack_seen), 16'h0);

        // R9: abort in settle cycle (release on the grant edge)
        ack_seen = 1'b0;
        sel_n = 1'b0; rd_wr = 1'b0; addr_i = 7'h32; data_i = 16'hCAFE;
        @(posedge clk); @(negedge clk);
        @(posedge clk); @(negedge clk);
        sel_n = 1'b1;
        repeat (3) begin
            @(posedge clk); @(negedge clk);
            if (!ack_n) ack_seen = 1'b1;
        end
        chk(!ack_seen, "R9 abort settle no ack", 16'(ack_seen), 16'h0);
        access(1'b1, 2'b00, 7'h30, 16'h0, got, got_oe, edges, held, rel, quiet);
        chk(got == 16'h0000, "R9 no write after lead abort", got, 16'h0000);
        access(1'b1, 2'b00, 7'h32, 16'h0, got, got_oe, edges, held, rel, quiet);
        chk(got == 16'h0000, "R9 no write after settle abort", got, 16'h0000);

        // R10: reset clears the bank
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        access(1'b1, 2'b00, 7'h7E, 16'h0, got, got_oe, edges, held, rel, quiet);
        chk(got == 16'h0000, "R10 bank cleared", got, 16'h0000);
        chk(alt_mode == 1'b0, "R11 mode pin after traffic", 16'(alt_mode), 16'h0);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule